// File: doc/BRIEF.md
# Polyphase Scaler Control Register Bank

This block is the software-facing register bank for a polyphase video scaler. It decodes a 32-bit word-addressed register port with per-byte write enables. Behind that port it holds the run/stop and edge-mode control word, the output frame size, three pixel-difference thresholds and four coefficient bank selectors. It also holds a row of staged coefficient taps. A write to a phase register moves the whole staged row into the horizontal or vertical coefficient memory. The bank that receives it is the one named by the matching write selector, and bit 15 of the phase word picks the edge coefficient set instead of the normal one.

The datapath pulses `frame_start` at the beginning of every frame. On that pulse, with the run bit set, the block copies all settings into a snapshot that stays fixed for the whole frame. The thresholds in that copy are multiplied by the number of colour planes. With the run bit clear, the block halts and the snapshot is left as it was. The coefficient memories have one registered read port per direction. These ports always read from the bank named in the snapshot, so software can refill an idle bank while a frame is being processed.

Top module: `scl_ctrl_top`

## Requirements
- R1: After reset every register reads zero, `run` is 0, all snapshot outputs are 0 and `reg_rvalid` is 0.
- R2: A read accepted in one cycle returns its data on `reg_rdata` in the next cycle, with `reg_rvalid` high for exactly that cycle, and `reg_wait` is always 0. Bits a register does not define read as 0. Offset 2 (interrupt) and every offset past the last tap read 0. The control word at offset 0 keeps only bits 2:0.
- R3: On a write, only the byte lanes whose `reg_be` bit is 1 change, with bit n enabling `reg_wdata[8n+7:8n]`. This applies to every register, including the 32-bit phase words at offsets 12 and 13.
- R4: Offset 0 holds run (bit 0), edge coefficient selection (bit 1) and edge sharpening (bit 2). At `frame_start`, `run` takes the value of bit 0, and the status bit at offset 1 reads `run`. Clearing bit 0 mid-frame leaves `run` at 1 until the next `frame_start`.
- R5: The snapshot outputs (size, thresholds, mode bits, read banks) change only at a `frame_start` seen while bit 0 of offset 0 is 1. Register writes between frame starts do not change them.
- R6: The snapshot thresholds are the register values (offset 5 edge, 6 lower blur, 7 upper blur) times NUM_PLANES.
- R7: Offsets 14 to 14+NTAPS-1 stage one tap each and read back. Writing them changes no coefficient memory content.
- R8: A write to offset 12 stores the staged taps 0..H_TAPS-1 into the horizontal bank chosen by offset 8, at the phase given by the low bits of the merged phase word. Bit 15 set selects the edge set. Every such write commits again, even if the phase value is repeated.
- R9: A write to offset 13 does the same for taps 0..V_TAPS-1 into the vertical bank chosen by offset 10.
- R10: Each coefficient read port returns, one cycle after the phase and edge inputs are presented, the row from the bank that offset 9 (horizontal) or offset 11 (vertical) held at the last latching frame start. Tap k appears at bits [16k+15:16k].
- R11: The bank selectors at offsets 8 to 11 keep only log2(banks) bits. A commit lands in the bank the write selector holds at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W (5) | Register word offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid pulse |
| reg_wait | output | 1 | Stall request, held low |
| frame_start | input | 1 | Frame boundary pulse from the datapath |
| run | output | 1 | Core running for this frame |
| cfg_edge_en | output | 1 | Snapshot edge coefficient selection enable |
| cfg_sharp_en | output | 1 | Snapshot edge sharpening enable |
| cfg_out_w | output | DIM_W (16) | Snapshot output width in pixels |
| cfg_out_h | output | DIM_W (16) | Snapshot output height in pixels |
| cfg_edge_thr | output | TS_W (10) | Scaled edge threshold |
| cfg_blur_lo | output | TS_W (10) | Scaled lower blur threshold |
| cfg_blur_hi | output | TS_W (10) | Scaled upper blur threshold |
| h_rd_phase | input | log2(H_PHASES) | Horizontal read phase |
| h_rd_edge | input | 1 | Horizontal read selects edge set |
| h_rd_taps | output | H_TAPS*COEF_W | Horizontal coefficient row |
| v_rd_phase | input | log2(V_PHASES) | Vertical read phase |
| v_rd_edge | input | 1 | Vertical read selects edge set |
| v_rd_taps | output | V_TAPS*COEF_W | Vertical coefficient row |

## Verification
The assertions assume that `reg_wr`, `reg_rd` and `frame_start` are 0 throughout reset. They also assume that a read and a write are never issued in the same cycle, and that the coefficient read inputs stay at known values. The bench meets these assumptions: it drives every input from tasks at the falling edge, issues one register operation at a time, and releases reset with all strobes low. The coefficient memories are only read at entries that were committed earlier, so no check depends on uninitialised content.

// File: rtl/scl_pkg.sv
package scl_pkg;
   localparam int OFS_CTRL  = 0;
   localparam int OFS_STAT  = 1;
   localparam int OFS_INTR  = 2;
   localparam int OFS_WID   = 3;
   localparam int OFS_HEI   = 4;
   localparam int OFS_ETHR  = 5;
   localparam int OFS_BLO   = 6;
   localparam int OFS_BHI   = 7;
   localparam int OFS_HWB   = 8;
   localparam int OFS_HRB   = 9;
   localparam int OFS_VWB   = 10;
   localparam int OFS_VRB   = 11;
   localparam int OFS_HPH   = 12;
   localparam int OFS_VPH   = 13;
   localparam int OFS_STAGE = 14;
   localparam int EDGE_BIT  = 15;

   function automatic logic [31:0] be_merge(input logic [31:0] old_w,
                                            input logic [31:0] new_w,
                                            input logic [3:0]  be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
      return r;
   endfunction
endpackage

// File: rtl/scl_coef_bank.sv
module scl_coef_bank #(
   parameter int BANKS  = 2,
   parameter int PHASES = 8,
   parameter int TAPS   = 4,
   parameter int COEF_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(BANKS)-1:0]   wr_bank,
   input  logic                       wr_edge,
   input  logic [$clog2(PHASES)-1:0]  wr_phase,
   input  logic [TAPS*COEF_W-1:0]     wr_taps,
   input  logic [$clog2(BANKS)-1:0]   rd_bank,
   input  logic                       rd_edge,
   input  logic [$clog2(PHASES)-1:0]  rd_phase,
   output logic [TAPS*COEF_W-1:0]     rd_taps
);
   localparam int BK_W  = $clog2(BANKS);
   localparam int PH_W  = $clog2(PHASES);
   localparam int ROW_W = TAPS * COEF_W;
   localparam int DEPTH = BANKS * 2 * PHASES;
   localparam int KEY_W = BK_W + 1 + PH_W;

   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("scl_coef_bank: BANKS must be a power of two, at least 2");
   end
   if (PHASES < 2 || (PHASES & (PHASES - 1)) != 0) begin : g_bad_phases
      $error("scl_coef_bank: PHASES must be a power of two, at least 2");
   end
   if (DEPTH * ROW_W > 65536) begin : g_too_big
      $error("scl_coef_bank: memory exceeds size limit");
   end

   logic [ROW_W-1:0] mem [DEPTH];
   logic [KEY_W-1:0] wr_key;
   logic [KEY_W-1:0] rd_key;

   assign wr_key = {wr_bank, wr_edge, wr_phase};
   assign rd_key = {rd_bank, rd_edge, rd_phase};

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_key] <= wr_taps;
      rd_taps <= mem[rd_key];
   end

   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               warm_q <= '0;
      else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
   end

   // R10: no commit and an unchanged read key keep the read row steady
   p_read_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd3 && !$past(wr_en) && $stable(rd_key)) |=> $stable(rd_taps));
endmodule

// File: rtl/scl_reg_file.sv
module scl_reg_file
   import scl_pkg::*;
#(
   parameter int NTAPS  = 4,
   parameter int COEF_W = 16,
   parameter int DIM_W  = 16,
   parameter int THR_W  = 8,
   parameter int HB_W   = 1,
   parameter int VB_W   = 1,
   parameter int HPH_W  = 3,
   parameter int VPH_W  = 3,
   parameter int ADDR_W = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic                    reg_wr,
   input  logic                    reg_rd,
   input  logic [3:0]              reg_be,
   input  logic [31:0]             reg_wdata,
   output logic [31:0]             reg_rdata,
   output logic                    reg_rvalid,
   input  logic                    run_state,
   output logic                    go,
   output logic                    edge_en,
   output logic                    sharp_en,
   output logic [DIM_W-1:0]        out_w,
   output logic [DIM_W-1:0]        out_h,
   output logic [THR_W-1:0]        edge_thr,
   output logic [THR_W-1:0]        blur_lo,
   output logic [THR_W-1:0]        blur_hi,
   output logic [HB_W-1:0]         hbank_wr,
   output logic [HB_W-1:0]         hbank_rd,
   output logic [VB_W-1:0]         vbank_wr,
   output logic [VB_W-1:0]         vbank_rd,
   output logic                    h_commit,
   output logic                    v_commit,
   output logic                    commit_edge,
   output logic [HPH_W-1:0]        h_phase_idx,
   output logic [VPH_W-1:0]        v_phase_idx,
   output logic [NTAPS*COEF_W-1:0] stage_flat
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_INTR = ADDR_W'(OFS_INTR);
   localparam logic [ADDR_W-1:0] A_WID  = ADDR_W'(OFS_WID);
   localparam logic [ADDR_W-1:0] A_HEI  = ADDR_W'(OFS_HEI);
   localparam logic [ADDR_W-1:0] A_ETHR = ADDR_W'(OFS_ETHR);
   localparam logic [ADDR_W-1:0] A_BLO  = ADDR_W'(OFS_BLO);
   localparam logic [ADDR_W-1:0] A_BHI  = ADDR_W'(OFS_BHI);
   localparam logic [ADDR_W-1:0] A_HWB  = ADDR_W'(OFS_HWB);
   localparam logic [ADDR_W-1:0] A_HRB  = ADDR_W'(OFS_HRB);
   localparam logic [ADDR_W-1:0] A_VWB  = ADDR_W'(OFS_VWB);
   localparam logic [ADDR_W-1:0] A_VRB  = ADDR_W'(OFS_VRB);
   localparam logic [ADDR_W-1:0] A_HPH  = ADDR_W'(OFS_HPH);
   localparam logic [ADDR_W-1:0] A_VPH  = ADDR_W'(OFS_VPH);

   logic [2:0]        ctrl_q;
   logic [DIM_W-1:0]  wid_q, hei_q;
   logic [THR_W-1:0]  ethr_q, blo_q, bhi_q;
   logic [HB_W-1:0]   hwb_q, hrb_q;
   logic [VB_W-1:0]   vwb_q, vrb_q;
   logic [31:0]       hph_q, vph_q;
   logic [COEF_W-1:0] stage_q [NTAPS];
   logic [31:0]       cur;
   logic [31:0]       merged;
   logic              in_stage;

   // Current contents of the addressed word; shared by reads and by the byte merge
   always_comb begin
      cur      = '0;
      in_stage = 1'b0;
      case (reg_addr)
         A_CTRL: cur[2:0]         = ctrl_q;
         A_STAT: cur[0]           = run_state;
         A_WID:  cur[DIM_W-1:0]   = wid_q;
         A_HEI:  cur[DIM_W-1:0]   = hei_q;
         A_ETHR: cur[THR_W-1:0]   = ethr_q;
         A_BLO:  cur[THR_W-1:0]   = blo_q;
         A_BHI:  cur[THR_W-1:0]   = bhi_q;
         A_HWB:  cur[HB_W-1:0]    = hwb_q;
         A_HRB:  cur[HB_W-1:0]    = hrb_q;
         A_VWB:  cur[VB_W-1:0]    = vwb_q;
         A_VRB:  cur[VB_W-1:0]    = vrb_q;
         A_HPH:  cur              = hph_q;
         A_VPH:  cur              = vph_q;
         default: ;
      endcase
      for (int k = 0; k < NTAPS; k++) begin
         if (reg_addr == ADDR_W'(OFS_STAGE + k)) begin
            cur[COEF_W-1:0] = stage_q[k];
            in_stage        = 1'b1;
         end
      end
   end

   assign merged = be_merge(cur, reg_wdata, reg_be);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0; wid_q <= '0; hei_q <= '0;
         ethr_q <= '0; blo_q <= '0; bhi_q <= '0;
         hwb_q  <= '0; hrb_q <= '0; vwb_q <= '0; vrb_q <= '0;
         hph_q  <= '0; vph_q <= '0;
         for (int k = 0; k < NTAPS; k++) stage_q[k] <= '0;
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               A_CTRL: ctrl_q <= merged[2:0];
               A_WID:  wid_q  <= merged[DIM_W-1:0];
               A_HEI:  hei_q  <= merged[DIM_W-1:0];
               A_ETHR: ethr_q <= merged[THR_W-1:0];
               A_BLO:  blo_q  <= merged[THR_W-1:0];
               A_BHI:  bhi_q  <= merged[THR_W-1:0];
               A_HWB:  hwb_q  <= merged[HB_W-1:0];
               A_HRB:  hrb_q  <= merged[HB_W-1:0];
               A_VWB:  vwb_q  <= merged[VB_W-1:0];
               A_VRB:  vrb_q  <= merged[VB_W-1:0];
               A_HPH:  hph_q  <= merged;
               A_VPH:  vph_q  <= merged;
               default: ;
            endcase
            for (int k = 0; k < NTAPS; k++)
               if (reg_addr == ADDR_W'(OFS_STAGE + k)) stage_q[k] <= merged[COEF_W-1:0];
         end
         reg_rvalid <= reg_rd;
         reg_rdata  <= reg_rd ? cur : '0;
      end
   end

   assign go       = ctrl_q[0];
   assign edge_en  = ctrl_q[1];
   assign sharp_en = ctrl_q[2];
   assign out_w    = wid_q;
   assign out_h    = hei_q;
   assign edge_thr = ethr_q;
   assign blur_lo  = blo_q;
   assign blur_hi  = bhi_q;
   assign hbank_wr = hwb_q;
   assign hbank_rd = hrb_q;
   assign vbank_wr = vwb_q;
   assign vbank_rd = vrb_q;

   // A phase write is the commit strobe; its merged value carries phase and set
   assign h_commit    = reg_wr && (reg_addr == A_HPH);
   assign v_commit    = reg_wr && (reg_addr == A_VPH);
   assign commit_edge = merged[EDGE_BIT];
   assign h_phase_idx = merged[HPH_W-1:0];
   assign v_phase_idx = merged[VPH_W-1:0];

   for (genvar k = 0; k < NTAPS; k++) begin : g_stage
      assign stage_flat[k*COEF_W +: COEF_W] = stage_q[k];
   end

   // R7: staged taps move only on a write to the staging window
   p_stage_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && in_stage) |=> $stable(stage_flat));

   // R2: the interrupt word always reads as zero
   p_intr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_INTR) |=> (reg_rvalid && reg_rdata == '0));
endmodule

// File: rtl/scl_frame_latch.sv
module scl_frame_latch #(
   parameter int DIM_W      = 16,
   parameter int THR_W      = 8,
   parameter int TS_W       = 10,
   parameter int NUM_PLANES = 3,
   parameter int HB_W       = 1,
   parameter int VB_W       = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             go,
   input  logic             edge_en,
   input  logic             sharp_en,
   input  logic [DIM_W-1:0] out_w,
   input  logic [DIM_W-1:0] out_h,
   input  logic [THR_W-1:0] edge_thr,
   input  logic [THR_W-1:0] blur_lo,
   input  logic [THR_W-1:0] blur_hi,
   input  logic [HB_W-1:0]  hbank_rd,
   input  logic [VB_W-1:0]  vbank_rd,
   output logic             run,
   output logic             cfg_edge_en,
   output logic             cfg_sharp_en,
   output logic [DIM_W-1:0] cfg_out_w,
   output logic [DIM_W-1:0] cfg_out_h,
   output logic [TS_W-1:0]  cfg_edge_thr,
   output logic [TS_W-1:0]  cfg_blur_lo,
   output logic [TS_W-1:0]  cfg_blur_hi,
   output logic [HB_W-1:0]  cfg_hbank,
   output logic [VB_W-1:0]  cfg_vbank
);
   localparam logic [TS_W-1:0] PLANES = TS_W'(NUM_PLANES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cfg_edge_en <= 1'b0; cfg_sharp_en <= 1'b0;
         cfg_out_w <= '0; cfg_out_h <= '0;
         cfg_edge_thr <= '0; cfg_blur_lo <= '0; cfg_blur_hi <= '0;
         cfg_hbank <= '0; cfg_vbank <= '0;
      end else if (frame_start) begin
         run <= go;
         if (go) begin
            cfg_edge_en  <= edge_en;
            cfg_sharp_en <= sharp_en;
            cfg_out_w    <= out_w;
            cfg_out_h    <= out_h;
            cfg_edge_thr <= TS_W'(edge_thr) * PLANES;
            cfg_blur_lo  <= TS_W'(blur_lo) * PLANES;
            cfg_blur_hi  <= TS_W'(blur_hi) * PLANES;
            cfg_hbank    <= hbank_rd;
            cfg_vbank    <= vbank_rd;
         end
      end
   end

   // R5: between frame starts the snapshot does not move
   p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(cfg_out_w) && $stable(cfg_out_h) &&
                        $stable(cfg_edge_thr) && $stable(cfg_hbank) && $stable(cfg_vbank)));

   // R4: a frame start with run cleared halts without touching the snapshot
   p_stop_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !go) |=> (!run && $stable(cfg_out_w) && $stable(cfg_blur_hi)));
endmodule

// File: rtl/scl_ctrl_top.sv
module scl_ctrl_top #(
   parameter int NUM_PLANES = 3,
   parameter int H_TAPS     = 4,
   parameter int V_TAPS     = 3,
   parameter int H_PHASES   = 8,
   parameter int V_PHASES   = 8,
   parameter int H_BANKS    = 2,
   parameter int V_BANKS    = 2,
   parameter int COEF_W     = 16,
   parameter int DIM_W      = 16,
   parameter int THR_W      = 8,
   localparam int NTAPS  = (H_TAPS > V_TAPS) ? H_TAPS : V_TAPS,
   localparam int ADDR_W = $clog2(scl_pkg::OFS_STAGE + NTAPS),
   localparam int HPH_W  = $clog2(H_PHASES),
   localparam int VPH_W  = $clog2(V_PHASES),
   localparam int HB_W   = $clog2(H_BANKS),
   localparam int VB_W   = $clog2(V_BANKS),
   localparam int TS_W   = THR_W + $clog2(NUM_PLANES + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [3:0]               reg_be,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   output logic                     reg_rvalid,
   output logic                     reg_wait,
   input  logic                     frame_start,
   output logic                     run,
   output logic                     cfg_edge_en,
   output logic                     cfg_sharp_en,
   output logic [DIM_W-1:0]         cfg_out_w,
   output logic [DIM_W-1:0]         cfg_out_h,
   output logic [TS_W-1:0]          cfg_edge_thr,
   output logic [TS_W-1:0]          cfg_blur_lo,
   output logic [TS_W-1:0]          cfg_blur_hi,
   input  logic [HPH_W-1:0]         h_rd_phase,
   input  logic                     h_rd_edge,
   output logic [H_TAPS*COEF_W-1:0] h_rd_taps,
   input  logic [VPH_W-1:0]         v_rd_phase,
   input  logic                     v_rd_edge,
   output logic [V_TAPS*COEF_W-1:0] v_rd_taps
);
   if (COEF_W < 2 || COEF_W > 32) begin : g_bad_coef
      $error("scl_ctrl_top: COEF_W must lie in 2..32");
   end
   if (DIM_W < 1 || DIM_W > 32 || THR_W < 1 || THR_W > 16) begin : g_bad_w
      $error("scl_ctrl_top: DIM_W must lie in 1..32 and THR_W in 1..16");
   end
   if (HPH_W > scl_pkg::EDGE_BIT || VPH_W > scl_pkg::EDGE_BIT) begin : g_bad_ph
      $error("scl_ctrl_top: phase index would overlap the edge-set bit");
   end
   if (NUM_PLANES < 1) begin : g_bad_pl
      $error("scl_ctrl_top: NUM_PLANES must be at least 1");
   end

   logic                    go, edge_en, sharp_en;
   logic [DIM_W-1:0]        out_w, out_h;
   logic [THR_W-1:0]        edge_thr, blur_lo, blur_hi;
   logic [HB_W-1:0]         hbank_wr, hbank_rd, cfg_hbank;
   logic [VB_W-1:0]         vbank_wr, vbank_rd, cfg_vbank;
   logic                    h_commit, v_commit, commit_edge;
   logic [HPH_W-1:0]        h_phase_idx;
   logic [VPH_W-1:0]        v_phase_idx;
   logic [NTAPS*COEF_W-1:0] stage_flat;

   assign reg_wait = 1'b0;

   scl_reg_file #(
      .NTAPS(NTAPS), .COEF_W(COEF_W), .DIM_W(DIM_W), .THR_W(THR_W),
      .HB_W(HB_W), .VB_W(VB_W), .HPH_W(HPH_W), .VPH_W(VPH_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
      .run_state(run), .go(go), .edge_en(edge_en), .sharp_en(sharp_en),
      .out_w(out_w), .out_h(out_h), .edge_thr(edge_thr), .blur_lo(blur_lo), .blur_hi(blur_hi),
      .hbank_wr(hbank_wr), .hbank_rd(hbank_rd), .vbank_wr(vbank_wr), .vbank_rd(vbank_rd),
      .h_commit(h_commit), .v_commit(v_commit), .commit_edge(commit_edge),
      .h_phase_idx(h_phase_idx), .v_phase_idx(v_phase_idx), .stage_flat(stage_flat)
   );

   scl_frame_latch #(
      .DIM_W(DIM_W), .THR_W(THR_W), .TS_W(TS_W), .NUM_PLANES(NUM_PLANES),
      .HB_W(HB_W), .VB_W(VB_W)
   ) u_latch (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .go(go),
      .edge_en(edge_en), .sharp_en(sharp_en), .out_w(out_w), .out_h(out_h),
      .edge_thr(edge_thr), .blur_lo(blur_lo), .blur_hi(blur_hi),
      .hbank_rd(hbank_rd), .vbank_rd(vbank_rd), .run(run),
      .cfg_edge_en(cfg_edge_en), .cfg_sharp_en(cfg_sharp_en),
      .cfg_out_w(cfg_out_w), .cfg_out_h(cfg_out_h), .cfg_edge_thr(cfg_edge_thr),
      .cfg_blur_lo(cfg_blur_lo), .cfg_blur_hi(cfg_blur_hi),
      .cfg_hbank(cfg_hbank), .cfg_vbank(cfg_vbank)
   );

   scl_coef_bank #(
      .BANKS(H_BANKS), .PHASES(H_PHASES), .TAPS(H_TAPS), .COEF_W(COEF_W)
   ) u_hcoef (
      .clk(clk), .rst_n(rst_n), .wr_en(h_commit), .wr_bank(hbank_wr), .wr_edge(commit_edge),
      .wr_phase(h_phase_idx), .wr_taps(stage_flat[H_TAPS*COEF_W-1:0]),
      .rd_bank(cfg_hbank), .rd_edge(h_rd_edge), .rd_phase(h_rd_phase), .rd_taps(h_rd_taps)
   );

   scl_coef_bank #(
      .BANKS(V_BANKS), .PHASES(V_PHASES), .TAPS(V_TAPS), .COEF_W(COEF_W)
   ) u_vcoef (
      .clk(clk), .rst_n(rst_n), .wr_en(v_commit), .wr_bank(vbank_wr), .wr_edge(commit_edge),
      .wr_phase(v_phase_idx), .wr_taps(stage_flat[V_TAPS*COEF_W-1:0]),
      .rd_bank(cfg_vbank), .rd_edge(v_rd_edge), .rd_phase(v_rd_phase), .rd_taps(v_rd_taps)
   );

   // R4: the run flag follows the run bit held in the register file at each frame start
   p_run_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (run == $past(go)));
endmodule

// File: tb/tb_scl_ctrl_top.sv
module tb_scl_ctrl_top;
   localparam int AW = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_rvalid, reg_wait;
   logic        frame_start = 1'b0;
   logic        run, cfg_edge_en, cfg_sharp_en;
   logic [15:0] cfg_out_w, cfg_out_h;
   logic [9:0]  cfg_edge_thr, cfg_blur_lo, cfg_blur_hi;
   logic [2:0]  h_rd_phase = '0, v_rd_phase = '0;
   logic        h_rd_edge = 1'b0, v_rd_edge = 1'b0;
   logic [63:0] h_rd_taps;
   logic [47:0] v_rd_taps;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   scl_ctrl_top dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
      .reg_wait(reg_wait), .frame_start(frame_start), .run(run),
      .cfg_edge_en(cfg_edge_en), .cfg_sharp_en(cfg_sharp_en),
      .cfg_out_w(cfg_out_w), .cfg_out_h(cfg_out_h), .cfg_edge_thr(cfg_edge_thr),
      .cfg_blur_lo(cfg_blur_lo), .cfg_blur_hi(cfg_blur_hi),
      .h_rd_phase(h_rd_phase), .h_rd_edge(h_rd_edge), .h_rd_taps(h_rd_taps),
      .v_rd_phase(v_rd_phase), .v_rd_edge(v_rd_edge), .v_rd_taps(v_rd_taps)
   );

   // {is_read, req, addr[7:0], be[3:0], data-or-expected[31:0]}
   localparam int NV = 19;
   localparam logic [48:0] VEC [NV] = '{
      {1'b0, 4'd0,  8'd3,  4'hF, 32'h0000_0140},
      {1'b1, 4'd2,  8'd3,  4'hF, 32'h0000_0140},
      {1'b0, 4'd0,  8'd4,  4'h1, 32'hAAAA_BBF0},
      {1'b1, 4'd3,  8'd4,  4'hF, 32'h0000_00F0},
      {1'b0, 4'd0,  8'd4,  4'h2, 32'h0000_1200},
      {1'b1, 4'd3,  8'd4,  4'hF, 32'h0000_12F0},
      {1'b0, 4'd0,  8'd5,  4'hF, 32'hFFFF_FF7F},
      {1'b1, 4'd2,  8'd5,  4'hF, 32'h0000_007F},
      {1'b0, 4'd0,  8'd2,  4'hF, 32'hFFFF_FFFF},
      {1'b1, 4'd2,  8'd2,  4'hF, 32'h0000_0000},
      {1'b1, 4'd2,  8'd31, 4'hF, 32'h0000_0000},
      {1'b0, 4'd0,  8'd0,  4'hF, 32'hFFFF_FFF8},
      {1'b1, 4'd2,  8'd0,  4'hF, 32'h0000_0000},
      {1'b0, 4'd0,  8'd8,  4'hF, 32'h0000_0003},
      {1'b1, 4'd11, 8'd8,  4'hF, 32'h0000_0001},
      {1'b0, 4'd0,  8'd14, 4'hF, 32'h0001_8123},
      {1'b1, 4'd7,  8'd14, 4'hF, 32'h0000_8123},
      {1'b0, 4'd0,  8'd12, 4'hC, 32'hABCD_FFFF},
      {1'b1, 4'd3,  8'd12, 4'hF, 32'hABCD_0000}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input int a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      reg_addr = AW'(a); reg_be = be; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = '0;
   endtask

   task automatic rd_reg(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = AW'(a); reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      chk("R2 rvalid on read", 64'(reg_rvalid), 64'd1);
      d = reg_rdata;
   endtask

   task automatic pulse_frame();
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic h_read(input int ph, input logic e, output logic [63:0] t);
      @(negedge clk);
      h_rd_phase = 3'(ph); h_rd_edge = e;
      @(negedge clk);
      t = h_rd_taps;
   endtask

   task automatic v_read(input int ph, input logic e, output logic [47:0] t);
      @(negedge clk);
      v_rd_phase = 3'(ph); v_rd_edge = e;
      @(negedge clk);
      t = v_rd_taps;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [63:0] ht;
      logic [47:0] vt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 run after reset", 64'(run), 64'd0);
      chk("R1 rvalid after reset", 64'(reg_rvalid), 64'd0);
      chk("R1 cfg_out_w after reset", 64'(cfg_out_w), 64'd0);
      chk("R1 cfg_edge_thr after reset", 64'(cfg_edge_thr), 64'd0);
      chk("R2 wait low", 64'(reg_wait), 64'd0);
      rd_reg(0, d);  chk("R1 ctrl after reset", 64'(d), 64'd0);
      rd_reg(3, d);  chk("R1 width after reset", 64'(d), 64'd0);
      rd_reg(13, d); chk("R1 vphase after reset", 64'(d), 64'd0);
      @(negedge clk);
      chk("R2 rvalid single cycle", 64'(reg_rvalid), 64'd0);

      // Table walk: R2 R3 R7 R11 register behaviour
      for (int i = 0; i < NV; i++) begin
         logic [48:0] v;
         v = VEC[i];
         if (v[48]) begin
            rd_reg(int'(v[43:36]), d);
            chk($sformatf("R%0d table entry %0d", v[47:44], i), 64'(d), 64'(v[31:0]));
         end else begin
            wr_reg(int'(v[43:36]), v[35:32], v[31:0]);
         end
      end

      // R4: start
      wr_reg(0, 4'hF, 32'h7);
      rd_reg(1, d); chk("R4 status before start", 64'(d), 64'd0);
      chk("R4 run before start", 64'(run), 64'd0);
      pulse_frame();
      chk("R4 run after start", 64'(run), 64'd1);
      chk("R4 edge enable", 64'(cfg_edge_en), 64'd1);
      chk("R4 sharpen enable", 64'(cfg_sharp_en), 64'd1);
      chk("R5 width latched", 64'(cfg_out_w), 64'd320);
      chk("R5 height latched", 64'(cfg_out_h), 64'h12F0);
      chk("R6 edge thr scaled", 64'(cfg_edge_thr), 64'd381);
      rd_reg(1, d); chk("R4 status running", 64'(d), 64'd1);

      // R5 R6: mid-frame writes wait for the next frame
      wr_reg(3, 4'hF, 32'd640);
      wr_reg(6, 4'hF, 32'd10);
      wr_reg(7, 4'hF, 32'd200);
      chk("R5 width held mid-frame", 64'(cfg_out_w), 64'd320);
      chk("R5 blur lo held mid-frame", 64'(cfg_blur_lo), 64'd0);
      pulse_frame();
      chk("R5 width next frame", 64'(cfg_out_w), 64'd640);
      chk("R6 blur lo scaled", 64'(cfg_blur_lo), 64'd30);
      chk("R6 blur hi scaled", 64'(cfg_blur_hi), 64'd600);

      // R4: stop only at the frame boundary
      wr_reg(0, 4'hF, 32'h0);
      chk("R4 run kept after clear", 64'(run), 64'd1);
      rd_reg(1, d); chk("R4 status kept after clear", 64'(d), 64'd1);
      wr_reg(3, 4'hF, 32'd100);
      pulse_frame();
      chk("R4 run stopped", 64'(run), 64'd0);
      rd_reg(1, d); chk("R4 status stopped", 64'(d), 64'd0);
      chk("R5 width kept while stopped", 64'(cfg_out_w), 64'd640);

      // R8: horizontal commit into bank 1, phase 3, normal set
      wr_reg(14, 4'hF, 32'h11); wr_reg(15, 4'hF, 32'h22);
      wr_reg(16, 4'hF, 32'h33); wr_reg(17, 4'hF, 32'h44);
      wr_reg(12, 4'hF, 32'h0003);
      wr_reg(9, 4'hF, 32'h1);
      wr_reg(0, 4'hF, 32'h1);
      pulse_frame();
      h_read(3, 1'b0, ht);
      chk("R8 normal row bank1 ph3", ht, 64'h0044_0033_0022_0011);

      // R8: bit 15 targets the edge set
      wr_reg(14, 4'hF, 32'h55);
      wr_reg(12, 4'hF, 32'h8003);
      h_read(3, 1'b1, ht);
      chk("R8 edge row ph3", ht, 64'h0044_0033_0022_0055);
      h_read(3, 1'b0, ht);
      chk("R8 normal row untouched", ht, 64'h0044_0033_0022_0011);

      // R8: same phase value commits again
      wr_reg(15, 4'hF, 32'h66);
      wr_reg(12, 4'hF, 32'h8003);
      h_read(3, 1'b1, ht);
      chk("R8 repeated commit", ht, 64'h0044_0033_0066_0055);

      // R7: staging alone changes no memory
      wr_reg(16, 4'hF, 32'h777);
      h_read(3, 1'b1, ht);
      chk("R7 stage without commit", ht, 64'h0044_0033_0066_0055);
      rd_reg(16, d); chk("R7 stage readback", 64'(d), 64'h777);

      // R11 R10: write into bank 0, switch read bank at frame start
      wr_reg(8, 4'hF, 32'h0);
      wr_reg(12, 4'hF, 32'h0003);
      wr_reg(9, 4'hF, 32'h0);
      h_read(3, 1'b0, ht);
      chk("R10 read bank held until frame", ht, 64'h0044_0033_0022_0011);
      pulse_frame();
      h_read(3, 1'b0, ht);
      chk("R11 commit landed in bank0", ht, 64'h0044_0777_0066_0055);

      // R9: vertical commits
      wr_reg(10, 4'hF, 32'h1);
      wr_reg(13, 4'hF, 32'h0005);
      wr_reg(11, 4'hF, 32'h1);
      pulse_frame();
      v_read(5, 1'b0, vt);
      chk("R9 vertical row bank1 ph5", 64'(vt), 64'h0777_0066_0055);
      wr_reg(13, 4'hF, 32'h8002);
      v_read(2, 1'b1, vt);
      chk("R9 vertical edge row ph2", 64'(vt), 64'h0777_0066_0055);
      rd_reg(13, d); chk("R9 vphase readback", 64'(d), 64'h8002);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule